// File: doc/BRIEF.md
# Packet Class Tagger

This block sits in front of a per-class fair-queuing scheduler and labels each packet with the queue it belongs to. Packets arrive as 64-bit words with an 8-bit control sideband. One or more module header words come first, each with a nonzero control value. The first of these headers has control `0xFF` and carries the packet's byte length, word length and source port. Body words follow with control zero, and the final body word has a nonzero control value. Every packet has at least two body words.

The block holds back the header words and the first two body words in a small buffer. It needs them to see the IPv4 type-of-service byte. It then picks a queue index, either from the source port or from the top ToS bits, depending on a mode input. It emits one tag word with control `0x55`, then replays the buffered words and passes the rest of the packet straight through. Downstream backpressure stalls the input; no word is ever dropped or reordered.

Top module: `tagger`

## Requirements
- R1: Every packet is preceded on the output by exactly one tag word whose control value is `0x55`.
- R2: In the tag word, bits [63:40] are zero and bits [39:32] hold the queue index, which is always below NUM_Q.
- R3: The tag word carries the byte length in bits [15:0] and the word length in bits [31:16]. Both are copied from the header word with control `0xFF`, which holds the byte length in [15:0], the source port in [31:16] and the word length in [63:48].
- R4: With `cfg_tos_mode` high, the classifier looks at the second body word. If its bits [31:16] equal `0x0800`, the queue is ToS bits [7:5] (the word's bits [7:5]) modulo NUM_Q.
- R5: With `cfg_tos_mode` high, a packet whose second body word does not carry `0x0800` in bits [31:16] goes to queue 0.
- R6: With `cfg_tos_mode` low, the queue is the source port from the `0xFF` header, and a port of NUM_Q or more maps to queue 0.
- R7: After the tag word, all words of the packet appear with their data and control unchanged and in their original order.
- R8: The tag word is presented in the cycle after the second body word is accepted. While the tag and the buffered words are pending, `in_ready` is low.
- R9: While `out_valid` is high and `out_ready` is low, the output word stays stable and no word is lost.
- R10: During and right after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tos_mode | input | 1 | 1: classify by ToS, 0: classify by source port |
| in_data | input | 64 | Input word |
| in_ctrl | input | 8 | Input control sideband |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block accepts the input word |
| out_data | output | 64 | Output word |
| out_ctrl | output | 8 | Output control sideband |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream accepts the output word |

## Verification
The tag word becomes visible one register stage after the edge that accepts the second body word. Replayed words follow one per accepted output cycle. Pass-through words are combinational from input to output. The bench changes inputs just after a rising edge and samples every result at the following falling edge, so each check lands in the cycle where the value is due. The latency check counts exactly one edge from the deciding word to the tag. The stream checks compare the logged output sequence against an expected sequence built from the requirements, so they stay exact under random backpressure.

// File: rtl/tagger_pkg.sv
package tagger_pkg;
    localparam logic [7:0]  TAG_CTRL = 8'h55;
    localparam logic [7:0]  HDR_CTRL = 8'hFF;
    localparam logic [15:0] ETH_IPV4 = 16'h0800;

    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_TAG   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_PASS  = 2'd3
    } tag_state_e;
endpackage

// File: rtl/tagger_classify.sv
module tagger_classify #(
    parameter int NUM_Q = 4,
    parameter int QW    = 2
) (
    input  logic          use_tos,
    input  logic          is_ipv4,
    input  logic [7:0]    tos,
    input  logic [15:0]   port,
    output logic [QW-1:0] queue
);
    logic [31:0] prec;

    always_comb begin
        prec  = 32'(tos[7:5]) % NUM_Q;
        queue = '0;
        if (use_tos) begin
            if (is_ipv4) queue = QW'(prec);
        end else if (32'(port) < NUM_Q) begin
            queue = QW'(port);
        end
    end
endmodule

// File: rtl/tagger_hdr_buf.sv
module tagger_hdr_buf #(
    parameter int DEPTH = 6,
    parameter int AW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [63:0]   wr_data,
    input  logic [7:0]    wr_ctrl,
    input  logic          clr,
    input  logic [AW-1:0] rd_idx,
    output logic [63:0]   rd_data,
    output logic [7:0]    rd_ctrl,
    output logic [AW:0]   count
);
    logic [71:0] mem_q [DEPTH];
    logic [AW:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)        cnt_d = '0;
        else if (wr_en) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
        if (wr_en) mem_q[cnt_q[AW-1:0]] <= {wr_ctrl, wr_data};
    end

    assign rd_ctrl = mem_q[rd_idx][71:64];
    assign rd_data = mem_q[rd_idx][63:0];
    assign count   = cnt_q;
endmodule

// File: rtl/tagger.sv
module tagger
    import tagger_pkg::*;
#(
    parameter int NUM_Q   = 4,
    parameter int MAX_HDR = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_tos_mode,
    input  logic [63:0] in_data,
    input  logic [7:0]  in_ctrl,
    input  logic        in_valid,
    output logic        in_ready,
    output logic [63:0] out_data,
    output logic [7:0]  out_ctrl,
    output logic        out_valid,
    input  logic        out_ready
);
    localparam int DEPTH = MAX_HDR + 2;
    localparam int AW    = $clog2(DEPTH);
    localparam int QW    = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;

    typedef struct packed {
        tag_state_e  st;
        logic        seen_body;
        logic        pkt_done;
        logic [15:0] byte_len;
        logic [15:0] word_len;
        logic [15:0] port;
        logic [7:0]  queue;
        logic [AW-1:0] rd_idx;
    } regs_t;

    regs_t r_d, r_q;

    logic          wr_en, clr;
    logic [63:0]   buf_data;
    logic [7:0]    buf_ctrl;
    logic [AW:0]   buf_cnt;
    logic [AW:0]   rd_next;
    logic [QW-1:0] cls_q;

    tagger_classify #(.NUM_Q(NUM_Q), .QW(QW)) u_cls (
        .use_tos (cfg_tos_mode),
        .is_ipv4 (in_data[31:16] == ETH_IPV4),
        .tos     (in_data[7:0]),
        .port    (r_q.port),
        .queue   (cls_q)
    );

    tagger_hdr_buf #(.DEPTH(DEPTH), .AW(AW)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (in_data),
        .wr_ctrl (in_ctrl),
        .clr     (clr),
        .rd_idx  (r_q.rd_idx),
        .rd_data (buf_data),
        .rd_ctrl (buf_ctrl),
        .count   (buf_cnt)
    );

    assign rd_next = {1'b0, r_q.rd_idx} + {{AW{1'b0}}, 1'b1};

    always_comb begin
        r_d       = r_q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = '0;
        out_ctrl  = '0;
        wr_en     = 1'b0;
        clr       = 1'b0;
        unique case (r_q.st)
            ST_FILL: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    wr_en = 1'b1;
                    if (!r_q.seen_body) begin
                        if (in_ctrl == HDR_CTRL) begin
                            r_d.byte_len = in_data[15:0];
                            r_d.port     = in_data[31:16];
                            r_d.word_len = in_data[63:48];
                        end
                        if (in_ctrl == 8'h00) r_d.seen_body = 1'b1;
                    end else begin
                        r_d.queue     = 8'(cls_q);
                        r_d.pkt_done  = (in_ctrl != 8'h00);
                        r_d.seen_body = 1'b0;
                        r_d.st        = ST_TAG;
                    end
                end
            end
            ST_TAG: begin
                out_valid = 1'b1;
                out_ctrl  = TAG_CTRL;
                out_data  = {24'h0, r_q.queue, r_q.word_len, r_q.byte_len};
                if (out_ready) begin
                    r_d.st     = ST_DRAIN;
                    r_d.rd_idx = '0;
                end
            end
            ST_DRAIN: begin
                out_valid = 1'b1;
                out_ctrl  = buf_ctrl;
                out_data  = buf_data;
                if (out_ready) begin
                    if (rd_next == buf_cnt) begin
                        clr    = 1'b1;
                        r_d.st = r_q.pkt_done ? ST_FILL : ST_PASS;
                    end else begin
                        r_d.rd_idx = rd_next[AW-1:0];
                    end
                end
            end
            ST_PASS: begin
                out_valid = in_valid;
                out_ctrl  = in_ctrl;
                out_data  = in_data;
                in_ready  = out_ready;
                if (in_valid && out_ready && in_ctrl != 8'h00) r_d.st = ST_FILL;
            end
            default: r_d.st = ST_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/tagger_chk.sv
module tagger_chk #(
    parameter int NUM_Q = 4,
    parameter int DEPTH = 6,
    parameter int AW    = 3
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_ready,
    input logic [63:0] out_data,
    input logic [7:0]  out_ctrl,
    input logic        out_valid,
    input logic        out_ready,
    input logic [AW:0] buf_cnt
);
    // R2: tag word upper field clear, queue in range
    p_tag_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ctrl == 8'h55) |->
        (out_data[63:40] == 24'h0 && 32'(out_data[39:32]) < NUM_Q));

    // R8: input stalled while tag is presented
    p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ctrl == 8'h55) |-> !in_ready);

    // R1: one tag word per packet, never two in a row
    p_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_ctrl == 8'h55) |=>
        !(out_valid && out_ctrl == 8'h55));

    // R9: held output stays put
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
        (out_valid && $stable(out_data) && $stable(out_ctrl)));

    // R7: buffered words never exceed capacity
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        32'(buf_cnt) <= DEPTH);
endmodule

bind tagger tagger_chk #(.NUM_Q(NUM_Q), .DEPTH(DEPTH), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_data  (out_data),
    .out_ctrl  (out_ctrl),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .buf_cnt   (buf_cnt)
);

// File: tb/sim_tagger.sv
module sim_tagger;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_tos_mode = 1'b0;
    logic [63:0] in_data = '0;
    logic [7:0]  in_ctrl = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] out_data;
    logic [7:0]  out_ctrl;
    logic        out_valid;
    logic        out_ready = 1'b1;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    int rdy_mode = 0;

    always #5 clk = ~clk;

    tagger #(.NUM_Q(4), .MAX_HDR(4)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_tos_mode(cfg_tos_mode),
        .in_data(in_data), .in_ctrl(in_ctrl), .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_ctrl(out_ctrl), .out_valid(out_valid), .out_ready(out_ready)
    );

    typedef struct packed {
        logic        tos_mode;
        logic [2:0]  nhdr;
        logic [7:0]  port;
        logic [15:0] eth;
        logic [7:0]  tos;
        logic [3:0]  nbody;
        logic [7:0]  exp_q;
        logic [2:0]  req;
    } vec_t;

    // mode, headers, port, ethertype, tos, body words, expected queue, requirement
    localparam vec_t TBL [8] = '{
        '{1'b1, 3'd1, 8'd0, 16'h0800, 8'hA0, 4'd2, 8'd1, 3'd4},
        '{1'b1, 3'd2, 8'd1, 16'h0800, 8'hE0, 4'd5, 8'd3, 3'd4},
        '{1'b1, 3'd2, 8'd2, 16'h86DD, 8'hE0, 4'd3, 8'd0, 3'd5},
        '{1'b0, 3'd1, 8'd2, 16'h0800, 8'hE0, 4'd4, 8'd2, 3'd6},
        '{1'b0, 3'd3, 8'd6, 16'h0800, 8'h20, 4'd2, 8'd0, 3'd6},
        '{1'b0, 3'd2, 8'd3, 16'h86DD, 8'h00, 4'd6, 8'd3, 3'd6},
        '{1'b1, 3'd3, 8'd3, 16'h0800, 8'h5C, 4'd3, 8'd2, 3'd4},
        '{1'b1, 3'd4, 8'd0, 16'h0800, 8'h9F, 4'd7, 8'd0, 3'd4}
    };

    logic [63:0] exp_d [512];
    logic [7:0]  exp_c [512];
    int          exp_r [512];
    int          exp_n = 0;
    logic [63:0] log_d [512];
    logic [7:0]  log_c [512];
    int          log_n = 0;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        logic [7:0] lfsr = 8'hA5;
        forever begin
            @(posedge clk); #1;
            if (rdy_mode == 0) out_ready = 1'b1;
            else if (rdy_mode == 1) begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                out_ready = lfsr[0] | lfsr[2];
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready && log_n < 512) begin
            log_d[log_n] = out_data;
            log_c[log_n] = out_ctrl;
            log_n++;
        end
    end

    task automatic push_exp(input logic [63:0] d, input logic [7:0] c, input int r);
        exp_d[exp_n] = d; exp_c[exp_n] = c; exp_r[exp_n] = r; exp_n++;
    endtask

    task automatic send(input logic [63:0] d, input logic [7:0] c);
        in_valid = 1'b1; in_data = d; in_ctrl = c;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic send_pkt(input vec_t v, input int id);
        logic [15:0] blen;
        logic [63:0] w;
        logic [7:0]  c;
        blen = 16'(32'(v.nbody) * 8 - 2);
        cfg_tos_mode = v.tos_mode;
        push_exp({24'h0, v.exp_q, 12'h0, v.nbody, blen}, 8'h55, int'(v.req));
        for (int i = 0; i < int'(v.nhdr); i++) begin
            if (i == 0) begin w = {12'h0, v.nbody, 16'h0, 8'h0, v.port, blen}; c = 8'hFF; end
            else begin w = {32'hABCD0000 + 32'(id), 32'(i)}; c = 8'hF0 + 8'(i); end
            push_exp(w, c, 7);
            send(w, c);
        end
        for (int i = 0; i < int'(v.nbody); i++) begin
            if (i == 1) w = {16'hB0DE, 8'(id), 8'(i), v.eth, 8'h45, v.tos};
            else        w = {16'hD00D, 8'(id), 8'(i), 32'h12345678 ^ 32'(i)};
            c = (i == int'(v.nbody) - 1) ? 8'h80 : 8'h00;
            push_exp(w, c, 7);
            send(w, c);
        end
    endtask

    task automatic wait_drain();
        for (int k = 0; k < 2000 && log_n < exp_n; k++) @(negedge clk);
    endtask

    initial begin
        #(2_000_000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        vec_t dv;
        // R10: reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R10", 64'(out_valid), 64'd0);
        check(in_ready == 1'b1, "R10", 64'(in_ready), 64'd1);
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && in_ready == 1'b1, "R10", {62'd0, out_valid, in_ready}, 64'd1);
        @(posedge clk); #1;

        // vector table, free-flowing then random backpressure (R9)
        for (int ph = 0; ph < 2; ph++) begin
            rdy_mode = ph;
            for (int t = 0; t < 8; t++) send_pkt(TBL[t], ph * 16 + t);
            wait_drain();
        end
        rdy_mode = 2; out_ready = 1'b1;
        wait_drain();

        // R8/R9: tag latency, input stall and held output
        dv = '{1'b1, 3'd1, 8'd0, 16'h0800, 8'h60, 4'd2, 8'd3, 3'd4};
        cfg_tos_mode = 1'b1;
        push_exp({24'h0, 8'd3, 16'd2, 16'd14}, 8'h55, 4);
        push_exp({16'd2, 16'h0, 16'h0, 16'd14}, 8'hFF, 7);
        send({16'd2, 16'h0, 16'h0, 16'd14}, 8'hFF);
        push_exp(64'h0000_0000_0000_1111, 8'h00, 7);
        send(64'h0000_0000_0000_1111, 8'h00);
        push_exp({32'hB0DE0000, 16'h0800, 8'h45, dv.tos}, 8'h80, 7);
        send({32'hB0DE0000, 16'h0800, 8'h45, dv.tos}, 8'h80);
        out_ready = 1'b0;
        @(negedge clk);
        check(out_valid && out_ctrl == 8'h55, "R8", {out_ctrl, 55'd0, out_valid}, {8'h55, 55'd0, 1'b1});
        check(in_ready == 1'b0, "R8", 64'(in_ready), 64'd0);
        held = out_data;
        repeat (3) @(negedge clk);
        check(out_valid && out_ctrl == 8'h55 && out_data == held, "R9", out_data, held);
        check(in_ready == 1'b0, "R8", 64'(in_ready), 64'd0);
        @(posedge clk); #1; out_ready = 1'b1;
        wait_drain();
        repeat (4) @(negedge clk);

        // compare logged stream with expected stream
        check(log_n == exp_n, "R7", 64'(log_n), 64'(exp_n));
        for (int i = 0; i < exp_n && i < log_n; i++) begin
            if (exp_c[i] == 8'h55) begin
                check(log_c[i] == 8'h55, "R1", 64'(log_c[i]), 64'h55);
                check(log_d[i][63:40] == 24'h0, "R2", log_d[i], exp_d[i]);
                check(log_d[i][31:0] == exp_d[i][31:0], "R3", log_d[i], exp_d[i]);
                if (exp_r[i] == 4)      check(log_d[i][39:32] == exp_d[i][39:32], "R4", log_d[i], exp_d[i]);
                else if (exp_r[i] == 5) check(log_d[i][39:32] == exp_d[i][39:32], "R5", log_d[i], exp_d[i]);
                else                    check(log_d[i][39:32] == exp_d[i][39:32], "R6", log_d[i], exp_d[i]);
            end else begin
                check(log_d[i] == exp_d[i] && log_c[i] == exp_c[i], "R7", log_d[i], exp_d[i]);
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule